// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 512K bytes (19 address bits, 8 data bits). The host hands over one word at a time through a valid/ready handshake: an address, a write flag, write data, and for reads it gets the byte back with a one-cycle response pulse. The sequencer turns each request into active-low chip-enable, output-enable and write-enable waveforms. It also drives the address lines and controls a split data bus made of an output word, a drive enable and an input word.

Every strobe width and setup margin is a cycle count. Each count comes from a nanosecond timing parameter and the clock period, rounded up, with at least one cycle per phase. Output enable is kept high for every write, so the RAM's outputs are always floating while the sequencer drives the bus. A turnaround phase is inserted whenever the access direction changes. No request is taken until a power-up wait has elapsed after reset.

States and transitions: `S_BOOT` goes to `S_IDLE` when the power-up wait is over. `S_IDLE` goes to `S_TURN` if the accepted request changes direction, otherwise to `S_WSET` for a write or `S_RSTB` for a read. `S_TURN` goes to `S_WSET` or `S_RSTB` when its count expires. `S_WSET` goes to `S_WPULSE`. `S_WPULSE` goes to `S_WEND` when its count expires. `S_WEND` goes to `S_IDLE`. `S_RSTB` goes to `S_RCAP` when its count expires. `S_RCAP` goes to `S_IDLE`.

Top module: `sram_ctrl`

## Requirements
- R1: After reset all three strobes are high, the bus is not driven, ready and response valid are low, and nothing is accepted. Ready first rises on rising edge PWRUP_CYC+1 after reset release, where PWRUP_CYC = ceil(T_PWRUP_NS/CLK_NS).
- R2: A write holds chip enable low and pulls write enable low for exactly WR_CYC consecutive cycles. WR_CYC is the largest of ceil(T_PWE_NS/CLK_NS), ceil(T_SD_NS/CLK_NS), ceil(T_AW_NS/CLK_NS) and ceil(T_WC_NS/CLK_NS)-2, and at least 1.
- R3: Output enable stays high during every write, and the data drivers are enabled in every cycle in which write enable is low.
- R4: Write data on the bus does not change while write enable is low, and the drivers switch off in the same cycle that write enable rises.
- R5: A read holds chip enable and output enable low with write enable high for RD_CYC+1 cycles, where RD_CYC = ceil(T_AA_NS/CLK_NS). The input byte is captured at the end of that window and returned with a response valid pulse exactly one cycle wide.
- R6: Once a request is accepted, ready stays low until the transaction ends. For a write, ready returns WR_CYC+3 cycles after the accept edge; for a read, the response arrives RD_CYC+2 cycles after it, counted in falling edges after the accept edge.
- R7: When a request's direction differs from the previous accepted request, TA_CYC = ceil(T_HZOE_NS/CLK_NS) extra cycles with all strobes high precede the access. No turnaround is added for the first request after reset or for same-direction requests.
- R8: The data drivers are never enabled while output enable is low or within TA_CYC cycles after it rises.
- R9: A request presented while ready is low, including during the power-up wait, is not accepted and leaves memory unchanged.
- R10: Address and write data are latched at acceptance and held on the memory pins for the whole access, whatever the host does with its inputs afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read-data valid pulse |
| rsp_rdata | output | DW | Captured read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Memory address lines |
| mem_dq_out | output | DW | Data to drive onto the memory bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_in | input | DW | Data read from the memory bus |

## Verification
The hardest situation to reach is a read sampled too early, because the memory pins show some value whenever they are driven. The bench memory model therefore returns a poison byte until enough half-cycles have passed since the strobes and address settled, so a shortened read window shows up as wrong data. Direction changes are produced by a vector order that alternates writes and reads and also repeats each direction. An early driver turn-on after a read is caught by a float-time counter kept in the model. Requests during power-up and changed host inputs after acceptance are checked through later reads of the affected addresses.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        S_BOOT,
        S_IDLE,
        S_TURN,
        S_WSET,
        S_WPULSE,
        S_WEND,
        S_RSTB,
        S_RCAP
    } ctl_state_t;

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_pwrup.sv
module sram_ctrl_pwrup #(
    parameter int unsigned WAIT_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(WAIT_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != CW'(WAIT_CYC)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == CW'(WAIT_CYC));

    // once the wait is over it never restarts without reset (R1)
    p_done_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

endmodule

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int unsigned LOAD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LOAD_W-1:0] load_val,
    output logic              zero
);
    logic [LOAD_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // an expired phase count stays expired until reloaded (R2, R5, R7)
    p_zero_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (capture) begin
                rdata <= din;
            end
        end
    end

    // response is a single-cycle pulse (R5)
    p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_NS     = 10,
    parameter int unsigned AW         = 19,
    parameter int unsigned DW         = 8,
    parameter int unsigned T_PWRUP_NS = 100000,
    parameter int unsigned T_AA_NS    = 10,
    parameter int unsigned T_PWE_NS   = 7,
    parameter int unsigned T_SD_NS    = 6,
    parameter int unsigned T_AW_NS    = 7,
    parameter int unsigned T_WC_NS    = 10,
    parameter int unsigned T_HZOE_NS  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int unsigned RD_CYC    = ns_to_cyc(T_AA_NS, CLK_NS);
    localparam int unsigned WC_CYC    = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned WC_PULSE  = (WC_CYC > 3) ? WC_CYC - 2 : 1;
    localparam int unsigned WR_CYC    = max2(max2(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)),
                                             max2(ns_to_cyc(T_AW_NS, CLK_NS), WC_PULSE));
    localparam int unsigned TA_CYC    = ns_to_cyc(T_HZOE_NS, CLK_NS);
    localparam int unsigned PWRUP_CYC = ns_to_cyc(T_PWRUP_NS, CLK_NS);
    localparam int unsigned TMR_MAX   = max2(max2(RD_CYC, WR_CYC), TA_CYC);
    localparam int          TW        = (TMR_MAX > 1) ? $clog2(TMR_MAX) : 1;
    localparam int          RUN_W     = $clog2(WR_CYC + 1);
    localparam logic [TW-1:0] RD_LD   = TW'(RD_CYC - 1);
    localparam logic [TW-1:0] WR_LD   = TW'(WR_CYC - 1);
    localparam logic [TW-1:0] TA_LD   = TW'(TA_CYC - 1);

    ctl_state_t    state, nxt;
    logic          pwr_done;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          op_wr, prev_vld, prev_wr;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_wdata;
    logic          accept, turn_needed;

    sram_ctrl_pwrup #(.WAIT_CYC(PWRUP_CYC)) pwrup_i (
        .clk  (clk),
        .rst_n(rst_n),
        .done (pwr_done)
    );

    sram_ctrl_timer #(.LOAD_W(TW)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    sram_ctrl_rdcap #(.DW(DW)) rdcap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(state == S_RCAP),
        .din    (mem_dq_in),
        .rdata  (rsp_rdata),
        .rvalid (rsp_valid)
    );

    assign accept      = req_valid && req_ready;
    assign turn_needed = prev_vld && (prev_wr != req_write);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_BOOT;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_BOOT:   if (pwr_done) nxt = S_IDLE;
            S_IDLE:   if (req_valid) begin
                          if (turn_needed)    nxt = S_TURN;
                          else if (req_write) nxt = S_WSET;
                          else                nxt = S_RSTB;
                      end
            S_TURN:   if (tmr_zero) nxt = op_wr ? S_WSET : S_RSTB;
            S_WSET:   nxt = S_WPULSE;
            S_WPULSE: if (tmr_zero) nxt = S_WEND;
            S_WEND:   nxt = S_IDLE;
            S_RSTB:   if (tmr_zero) nxt = S_RCAP;
            S_RCAP:   nxt = S_IDLE;
            default:  nxt = S_BOOT;
        endcase
    end

    // phase counter load on entry to a timed state
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (nxt != state) begin
            unique case (nxt)
                S_TURN:   begin tmr_load = 1'b1; tmr_val = TA_LD; end
                S_WPULSE: begin tmr_load = 1'b1; tmr_val = WR_LD; end
                S_RSTB:   begin tmr_load = 1'b1; tmr_val = RD_LD; end
                default:  ;
            endcase
        end
    end

    // request latch and direction history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_wr    <= 1'b0;
            op_addr  <= '0;
            op_wdata <= '0;
            prev_vld <= 1'b0;
            prev_wr  <= 1'b0;
        end else if (accept) begin
            op_wr    <= req_write;
            op_addr  <= req_addr;
            op_wdata <= req_wdata;
            prev_vld <= 1'b1;
            prev_wr  <= req_write;
        end
    end

    assign mem_addr   = op_addr;
    assign mem_dq_out = op_wdata;

    // registered outputs, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            req_ready <= 1'b0;
        end else begin
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            req_ready <= 1'b0;
            unique case (nxt)
                S_IDLE:         req_ready <= 1'b1;
                S_WSET, S_WEND: mem_ce_n  <= 1'b0;
                S_WPULSE: begin
                    mem_ce_n  <= 1'b0;
                    mem_we_n  <= 1'b0;
                    mem_dq_oe <= 1'b1;
                end
                S_RSTB, S_RCAP: begin
                    mem_ce_n <= 1'b0;
                    mem_oe_n <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // checker state: length of the current write-enable low run
    logic [RUN_W-1:0] we_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run <= '0;
        end else if (!mem_we_n) begin
            we_run <= we_run + 1'b1;
        end else begin
            we_run <= '0;
        end
    end

    p_boot_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_done |-> (mem_ce_n && mem_we_n && !mem_dq_oe && !req_ready));

    p_we_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run == RUN_W'(WR_CYC)));

    p_write_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    p_oe_off_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe));

    p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> $stable(mem_dq_out));

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_dq_oe);

    p_read_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    p_ready_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    p_no_drive_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !req_ready && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_ctrl_tb_top;
    localparam int CLK_PERIOD = 4;
    localparam int AW = 19;
    localparam int DW = 8;
    localparam int T_PWRUP = 100000;
    localparam int T_AA = 10;
    localparam int T_HZ = 5;
    localparam logic [7:0] POISON = 8'hE7;

    function automatic int cdiv(input int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int PWR_EXP = T_PWRUP / CLK_PERIOD + ((T_PWRUP % CLK_PERIOD) != 0 ? 1 : 0);
    int WR_EXP, RD_EXP, TA_EXP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic          req_ready, rsp_valid;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, rsp_rdata;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = POISON;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_ctrl #(.CLK_NS(CLK_PERIOD), .AW(AW), .DW(DW), .T_PWRUP_NS(T_PWRUP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    bit booting = 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // behavioural memory model with access-time and float-time tracking
    logic [7:0]    mdl [logic [AW-1:0]];
    bit            wpend = 0;
    logic [AW-1:0] wa, last_ra;
    logic [7:0]    wd;
    int            rd_age = 0, oe_hi = 100, we_cnt = 0;
    bit            r3_bad = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            rd_age = 0; oe_hi = 100; we_cnt = 0; wpend = 0; r3_bad = 0;
            mem_dq_in = POISON;
        end else begin
            if (booting && (!mem_ce_n || !mem_we_n || !mem_oe_n || mem_dq_oe))
                chk(0, "R1 strobe during power-up", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
            // write capture: last sample before the strobe pair releases
            if (!mem_ce_n && !mem_we_n) begin
                wpend = 1; wa = mem_addr; wd = mem_dq_oe ? mem_dq_out : POISON;
            end else if (wpend) begin
                mdl[wa] = wd; wpend = 0;
            end
            // read: data valid only once T_AA has passed by the next rising edge
            if (!mem_ce_n && !mem_oe_n && mem_we_n && (rd_age == 0 || mem_addr == last_ra))
                rd_age++;
            else
                rd_age = 0;
            last_ra = mem_addr;
            if (rd_age * CLK_PERIOD >= T_AA)
                mem_dq_in = mdl.exists(mem_addr) ? mdl[mem_addr] : 8'h00;
            else
                mem_dq_in = POISON;
            // float-time tracking for the bus drivers
            if (!mem_oe_n) oe_hi = 0; else if (oe_hi < 100) oe_hi++;
            if (mem_dq_oe && (oe_hi < TA_EXP + 1))
                chk(0, "R8 driver on while memory may drive", oe_hi, TA_EXP + 1);
            // write-enable pulse measurement
            if (!mem_we_n) begin
                we_cnt++;
                if (!mem_oe_n || !mem_dq_oe || mem_ce_n) r3_bad = 1;
            end else if (we_cnt > 0) begin
                chk(we_cnt == WR_EXP, "R2 write pulse cycles", we_cnt, WR_EXP);
                chk(!r3_bad, "R3 oe high and drivers on during pulse", r3_bad, 0);
                chk(!mem_dq_oe, "R4 drivers released with write enable", mem_dq_oe, 0);
                we_cnt = 0; r3_bad = 0;
            end
        end
    end

    // {write, addr, wdata, expected read data}
    localparam int NV = 9;
    localparam logic [35:0] VEC [NV] = '{
        {1'b1, 19'h00010, 8'h5A, 8'h00},
        {1'b1, 19'h7FFFF, 8'hC3, 8'h00},
        {1'b0, 19'h00010, 8'h00, 8'h5A},
        {1'b0, 19'h7FFFF, 8'h00, 8'hC3},
        {1'b1, 19'h00000, 8'h3C, 8'h00},
        {1'b0, 19'h00000, 8'h00, 8'h3C},
        {1'b0, 19'h12345, 8'h00, 8'h00},
        {1'b1, 19'h00010, 8'h96, 8'h00},
        {1'b0, 19'h00010, 8'h00, 8'h96}
    };

    bit have_prev = 0;
    bit prev_wr = 0;

    task automatic run_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [DW-1:0] exp);
        int n;
        int want;
        bit turn;
        while (!req_ready) @(negedge clk);
        turn = have_prev && (prev_wr != wr);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        // scramble host inputs after acceptance (R10)
        req_valid = 0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
        n = 1;
        want = (wr ? WR_EXP + 3 : RD_EXP + 2) + (turn ? TA_EXP : 0);
        while (!(wr ? req_ready : rsp_valid) && n < 100) begin
            @(negedge clk);
            n++;
        end
        if (turn) chk(n == want, "R7 turnaround latency", n, want);
        else      chk(n == want, "R6 busy latency", n, want);
        if (!wr) begin
            chk(rsp_rdata == exp, "R5/R10 read data", rsp_rdata, exp);
            @(negedge clk);
            chk(!rsp_valid, "R5 response pulse width", rsp_valid, 0);
        end
        have_prev = 1; prev_wr = wr;
    endtask

    task automatic boot_wait(output int edges);
        edges = 0;
        booting = 1;
        @(negedge clk);
        rst_n = 1;
        while (edges < PWR_EXP + 10) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (req_ready) break;
        end
        req_valid = 0;
        booting = 0;
    endtask

    initial begin
        int edges;
        WR_EXP = imax(imax(cdiv(7), cdiv(6)), imax(cdiv(7), imax(cdiv(10) - 2, 1)));
        RD_EXP = cdiv(T_AA);
        TA_EXP = cdiv(T_HZ);

        #(CLK_PERIOD * 3 + 1);
        chk(!req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
            "R1 reset outputs", {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}, 6'b011100);

        // request held during power-up must be ignored (R9)
        req_valid = 1; req_write = 1; req_addr = 19'h12345; req_wdata = 8'hEE;
        boot_wait(edges);
        chk(edges == PWR_EXP + 1, "R1 power-up edges", edges, PWR_EXP + 1);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][35], VEC[i][34:16], VEC[i][15:8], VEC[i][7:0]);
        end

        // R9: the power-up request left 0x12345 unwritten (vector 6 read 00); read again
        run_op(1'b0, 19'h12345, 8'h00, 8'h00);

        // reset in the middle of a read
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 19'h7FFFF;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        rst_n = 0;
        #1;
        chk(!req_ready && mem_ce_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
            "R1 outputs on mid-access reset", {req_ready, mem_ce_n, mem_oe_n, mem_dq_oe, rsp_valid}, 5'b01100);
        have_prev = 0;
        boot_wait(edges);
        chk(edges == PWR_EXP + 1, "R1 power-up edges after reset", edges, PWR_EXP + 1);
        run_op(1'b0, 19'h7FFFF, 8'h00, 8'hC3);
        run_op(1'b1, 19'h00001, 8'hA5, 8'h00);
        run_op(1'b1, 19'h00002, 8'h0F, 8'h00);
        run_op(1'b0, 19'h00001, 8'h00, 8'hA5);

        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

endmodule